// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block drives a small multicycle load/store processor. The datapath, memory and register file sit outside it. A 4-bit micro-program counter addresses a constant control store. Each entry of the store is one micro-state. It carries the datapath enables and selects for that state, plus a 2-bit sequencing code.

The sequencing code chooses the next micro-address from one of three places:

- micro-address zero, which is instruction fetch;
- a dispatch table indexed by the 6-bit opcode from the instruction register;
- the current micro-address plus one.

The branch state also produces a conditional PC write. The equality flag from the datapath gates this write. Every other control output is a registered lookup of the current micro-address, so each output is stable for the whole micro-state.

An instruction takes between three and five micro-states:

- branch-if-equal: 3 states;
- R-type and OR-immediate: 4 states;
- store word: 4 states;
- load word: 5 states.

After the last state of each path the sequencer returns to fetch.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous reset, whether held from power-up or raised in the middle of an instruction, sets the micro-address to 0 on the next edge. The fetch control word is then presented.
- R2: Micro-state 0 (fetch) asserts the PC write, the IR load and the memory read. It moves to micro-state 1.
- R3: Micro-state 1 (decode) asserts only the operand load. The next micro-address is taken from the opcode dispatch table: 000000 goes to 4, 000100 goes to 3, 001101 goes to 6, 100011 goes to 8, and 101011 goes to 11.
- R4: On the R-type path, micro-state 4 sets the ALU operation to FUNC (code 10) with the register operand selected (ALU source 0). Micro-state 5 asserts the register write with destination select 1 (rd). Control then returns to 0.
- R5: On the OR-immediate path, micro-state 6 sets ALU source 1, zero extension (extension select 0) and ALU operation OR (code 01). Micro-state 7 asserts the register write with destination select 0 (rt). Control then returns to 0.
- R6: On the load path, micro-state 8 sets ALU source 1, sign extension (extension select 1) and ALU operation ADD (code 00). Micro-state 9 asserts the memory read. Micro-state 10 asserts the register write with memory-to-register select 1. Control then returns to 0.
- R7: On the store path, micro-state 11 sets ALU source 1, sign extension and ADD. Micro-state 12 asserts the memory write. Control then returns to 0.
- R8: Micro-state 3 (branch) sets the PC source to 1 (branch target), sign extension and ALU operation SUB (code 11). Its PC write equals the equality flag in that cycle. Control then returns to 0.
- R9: An opcode missing from the dispatch table sends decode straight back to micro-state 0. No register or memory write occurs for that instruction.
- R10: Any control output not named for a micro-state in R2 to R8 is 0 in that state. The memory read and memory write are never both asserted. The PC write is asserted only in fetch or in a taken branch.
- R11: Changing the opcode outside the decode state has no effect on the micro-address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field of the instruction register |
| eq_i | input | 1 | Equality flag from the datapath comparator |
| upc_o | output | 4 | Current micro-address |
| pc_wr_o | output | 1 | PC write enable |
| pc_src_o | output | 1 | PC source: 0 = PC+4, 1 = branch target |
| ir_ld_o | output | 1 | Instruction register load |
| opnd_ld_o | output | 1 | Load of the A and B operand registers |
| reg_dst_o | output | 1 | Register destination: 0 = rt, 1 = rd |
| reg_wr_o | output | 1 | Register file write |
| alu_src_o | output | 1 | ALU second operand: 0 = B, 1 = extended immediate |
| ext_sgn_o | output | 1 | Immediate extension: 0 = zero, 1 = sign |
| alu_op_o | output | 2 | ALU operation: 00 ADD, 01 OR, 10 FUNC, 11 SUB |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_to_reg_o | output | 1 | Write-back source: 0 = ALU result, 1 = memory data |

## Verification
The micro-address and its control word come from the same register. Both change one clock edge after the state that chose them, so every result is due exactly one cycle after the state it follows.

The PC write in the branch state is the one output that also follows the equality flag within the same cycle. The opcode acts only at the decode edge, one cycle before the path's first state appears.

The bench drives inputs and compares the micro-address and the full control word on falling edges. Each micro-state is therefore checked in the cycle it occupies. The return to fetch is checked one edge after each path's last state.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W = 6;
    localparam int UA_W = 4;
    localparam int STORE_DEPTH = 13;

    typedef enum logic [1:0] {
        SEQ_ZERO = 2'b00,
        SEQ_DISP = 2'b01,
        SEQ_INC  = 2'b10
    } seq_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_OR   = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_SUB  = 2'b11
    } alu_e;

    typedef struct packed {
        seq_e seq;
        logic pc_wr;
        logic pc_br;
        logic ir_ld;
        logic opnd_ld;
        logic reg_dst;
        logic reg_wr;
        logic alu_src;
        logic ext_sgn;
        alu_e alu_op;
        logic mem_rd;
        logic mem_wr;
        logic mem_to_reg;
    } uword_t;

    localparam uword_t UW_IDLE = '0;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;

    localparam logic [UA_W-1:0] US_FETCH  = 4'd0;
    localparam logic [UA_W-1:0] US_DECODE = 4'd1;
    localparam logic [UA_W-1:0] US_BEQ    = 4'd3;
    localparam logic [UA_W-1:0] US_R_EX   = 4'd4;
    localparam logic [UA_W-1:0] US_R_WB   = 4'd5;
    localparam logic [UA_W-1:0] US_ORI_EX = 4'd6;
    localparam logic [UA_W-1:0] US_ORI_WB = 4'd7;
    localparam logic [UA_W-1:0] US_LW_AD  = 4'd8;
    localparam logic [UA_W-1:0] US_LW_MEM = 4'd9;
    localparam logic [UA_W-1:0] US_LW_WB  = 4'd10;
    localparam logic [UA_W-1:0] US_SW_AD  = 4'd11;
    localparam logic [UA_W-1:0] US_SW_MEM = 4'd12;

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int UA_W  = useq_pkg::UA_W,
    parameter int DEPTH = useq_pkg::STORE_DEPTH
) (
    input  logic [UA_W-1:0] addr_i,
    output uword_t          word_o
);

    always_comb begin
        word_o = UW_IDLE;
        if (int'(addr_i) < DEPTH) begin
            case (addr_i)
                US_FETCH: begin
                    word_o.seq    = SEQ_INC;
                    word_o.pc_wr  = 1'b1;
                    word_o.ir_ld  = 1'b1;
                    word_o.mem_rd = 1'b1;
                end
                US_DECODE: begin
                    word_o.seq     = SEQ_DISP;
                    word_o.opnd_ld = 1'b1;
                end
                US_BEQ: begin
                    word_o.seq     = SEQ_ZERO;
                    word_o.pc_br   = 1'b1;
                    word_o.ext_sgn = 1'b1;
                    word_o.alu_op  = ALU_SUB;
                end
                US_R_EX: begin
                    word_o.seq    = SEQ_INC;
                    word_o.alu_op = ALU_FUNC;
                end
                US_R_WB: begin
                    word_o.seq     = SEQ_ZERO;
                    word_o.reg_dst = 1'b1;
                    word_o.reg_wr  = 1'b1;
                end
                US_ORI_EX: begin
                    word_o.seq     = SEQ_INC;
                    word_o.alu_src = 1'b1;
                    word_o.alu_op  = ALU_OR;
                end
                US_ORI_WB: begin
                    word_o.seq    = SEQ_ZERO;
                    word_o.reg_wr = 1'b1;
                end
                US_LW_AD, US_SW_AD: begin
                    word_o.seq     = SEQ_INC;
                    word_o.alu_src = 1'b1;
                    word_o.ext_sgn = 1'b1;
                    word_o.alu_op  = ALU_ADD;
                end
                US_LW_MEM: begin
                    word_o.seq    = SEQ_INC;
                    word_o.mem_rd = 1'b1;
                end
                US_LW_WB: begin
                    word_o.seq        = SEQ_ZERO;
                    word_o.reg_wr     = 1'b1;
                    word_o.mem_to_reg = 1'b1;
                end
                US_SW_MEM: begin
                    word_o.seq    = SEQ_ZERO;
                    word_o.mem_wr = 1'b1;
                end
                default: word_o = UW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OP_W = useq_pkg::OP_W,
    parameter int UA_W = useq_pkg::UA_W
) (
    input  logic [OP_W-1:0] opcode_i,
    output logic [UA_W-1:0] target_o,
    output logic            hit_o
);

    always_comb begin
        hit_o    = 1'b1;
        target_o = US_FETCH;
        case (opcode_i)
            OPC_RTYPE: target_o = US_R_EX;
            OPC_BEQ:   target_o = US_BEQ;
            OPC_ORI:   target_o = US_ORI_EX;
            OPC_LW:    target_o = US_LW_AD;
            OPC_SW:    target_o = US_SW_AD;
            default: begin
                hit_o    = 1'b0;
                target_o = US_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int UA_W = useq_pkg::UA_W
) (
    input  seq_e            seq_i,
    input  logic [UA_W-1:0] upc_i,
    input  logic [UA_W-1:0] disp_tgt_i,
    input  logic            disp_hit_i,
    output logic [UA_W-1:0] next_o
);

    always_comb begin
        case (seq_i)
            SEQ_INC:  next_o = upc_i + 1'b1;
            SEQ_DISP: next_o = disp_hit_i ? disp_tgt_i : '0;
            default:  next_o = '0;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OP_W = useq_pkg::OP_W,
    parameter int UA_W = useq_pkg::UA_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            eq_i,
    output logic [UA_W-1:0] upc_o,
    output logic            pc_wr_o,
    output logic            pc_src_o,
    output logic            ir_ld_o,
    output logic            opnd_ld_o,
    output logic            reg_dst_o,
    output logic            reg_wr_o,
    output logic            alu_src_o,
    output logic            ext_sgn_o,
    output logic [1:0]      alu_op_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            mem_to_reg_o
);

    typedef struct packed {
        logic [UA_W-1:0] upc;
        uword_t          word;
    } st_t;

    st_t             st_d;
    st_t             st_q;
    logic [UA_W-1:0] disp_tgt;
    logic            disp_hit;
    logic [UA_W-1:0] seq_next;
    logic [UA_W-1:0] addr_d;
    uword_t          word_d;

    useq_dispatch #(.OP_W(OP_W), .UA_W(UA_W)) u_disp (
        .opcode_i (opcode_i),
        .target_o (disp_tgt),
        .hit_o    (disp_hit)
    );

    useq_next #(.UA_W(UA_W)) u_next (
        .seq_i      (st_q.word.seq),
        .upc_i      (st_q.upc),
        .disp_tgt_i (disp_tgt),
        .disp_hit_i (disp_hit),
        .next_o     (seq_next)
    );

    useq_store #(.UA_W(UA_W)) u_store (
        .addr_i (addr_d),
        .word_o (word_d)
    );

    always_comb begin
        addr_d       = rst_i ? '0 : seq_next;
        st_d.upc     = addr_d;
        st_d.word    = word_d;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign upc_o        = st_q.upc;
    assign pc_wr_o      = st_q.word.pc_wr | (st_q.word.pc_br & eq_i);
    assign pc_src_o     = st_q.word.pc_br;
    assign ir_ld_o      = st_q.word.ir_ld;
    assign opnd_ld_o    = st_q.word.opnd_ld;
    assign reg_dst_o    = st_q.word.reg_dst;
    assign reg_wr_o     = st_q.word.reg_wr;
    assign alu_src_o    = st_q.word.alu_src;
    assign ext_sgn_o    = st_q.word.ext_sgn;
    assign alu_op_o     = st_q.word.alu_op;
    assign mem_rd_o     = st_q.word.mem_rd;
    assign mem_wr_o     = st_q.word.mem_wr;
    assign mem_to_reg_o = st_q.word.mem_to_reg;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
#(
    parameter int OP_W = useq_pkg::OP_W,
    parameter int UA_W = useq_pkg::UA_W
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [OP_W-1:0] opcode_i,
    input logic            eq_i,
    input logic [UA_W-1:0] upc_o,
    input logic            pc_wr_o,
    input logic            mem_rd_o,
    input logic            mem_wr_o,
    input logic            reg_wr_o
);

    logic op_known;
    assign op_known = (opcode_i == OPC_RTYPE) || (opcode_i == OPC_BEQ) ||
                      (opcode_i == OPC_ORI) || (opcode_i == OPC_LW) ||
                      (opcode_i == OPC_SW);

    assert_fetch_inc_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_FETCH) |=> (upc_o == US_DECODE));

    assert_disp_load_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_DECODE && opcode_i == OPC_LW) |=> (upc_o == US_LW_AD));

    assert_disp_store_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_DECODE && opcode_i == OPC_SW) |=> (upc_o == US_SW_AD));

    assert_rtype_ret_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_R_WB) |=> (upc_o == US_FETCH));

    assert_load_ret_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_LW_WB) |=> (upc_o == US_FETCH));

    assert_store_ret_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_SW_MEM) |=> (upc_o == US_FETCH));

    assert_branch_pcwr_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_BEQ) |-> (pc_wr_o == eq_i));

    assert_unknown_op_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (upc_o == US_DECODE && !op_known) |=> (upc_o == US_FETCH && !reg_wr_o && !mem_wr_o));

    assert_mem_excl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(mem_rd_o && mem_wr_o));

    assert_pcwr_where_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_wr_o |-> (upc_o == US_FETCH || upc_o == US_BEQ));

endmodule

bind useq_ctrl useq_ctrl_chk #(.OP_W(OP_W), .UA_W(UA_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .opcode_i (opcode_i),
    .eq_i     (eq_i),
    .upc_o    (upc_o),
    .pc_wr_o  (pc_wr_o),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .reg_wr_o (reg_wr_o)
);

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic       eq;
    logic [3:0] upc;
    logic       pc_wr, pc_src, ir_ld, opnd_ld, reg_dst, reg_wr;
    logic       alu_src, ext_sgn, mem_rd, mem_wr, mem_to_reg;
    logic [1:0] alu_op;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    useq_ctrl u_useq_ctrl (
        .clk_i(clk), .rst_i(rst), .opcode_i(opcode), .eq_i(eq),
        .upc_o(upc), .pc_wr_o(pc_wr), .pc_src_o(pc_src), .ir_ld_o(ir_ld),
        .opnd_ld_o(opnd_ld), .reg_dst_o(reg_dst), .reg_wr_o(reg_wr),
        .alu_src_o(alu_src), .ext_sgn_o(ext_sgn), .alu_op_o(alu_op),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_to_reg_o(mem_to_reg)
    );

    // {pc_wr,pc_src,ir_ld,opnd_ld,reg_dst,reg_wr,alu_src,ext_sgn,alu_op,mem_rd,mem_wr,mem_to_reg}
    function automatic logic [12:0] exp_ctl(int s, logic e);
        logic [12:0] v = '0;
        case (s)
            0:       v = {1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, 2'b00, 1'b1, 2'b00};
            1:       v = {3'b000, 1'b1, 4'b0000, 2'b00, 3'b000};
            3:       v = {e, 1'b1, 2'b00, 3'b000, 1'b1, 2'b11, 3'b000};
            4:       v = {8'b0, 2'b10, 3'b000};
            5:       v = {4'b0000, 1'b1, 1'b1, 2'b00, 2'b00, 3'b000};
            6:       v = {6'b0, 1'b1, 1'b0, 2'b01, 3'b000};
            7:       v = {5'b0, 1'b1, 2'b00, 2'b00, 3'b000};
            8, 11:   v = {6'b0, 1'b1, 1'b1, 2'b00, 3'b000};
            9:       v = {10'b0, 3'b100};
            10:      v = {5'b0, 1'b1, 2'b00, 2'b00, 3'b001};
            12:      v = {10'b0, 3'b010};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string req_of(int s);
        case (s)
            0:       return "R2";
            1:       return "R3";
            3:       return "R8";
            4, 5:    return "R4";
            6, 7:    return "R5";
            8, 9, 10: return "R6";
            11, 12:  return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check_state(int s, string req);
        logic [12:0] got;
        logic [12:0] want;
        got  = {pc_wr, pc_src, ir_ld, opnd_ld, reg_dst, reg_wr, alu_src, ext_sgn,
                alu_op, mem_rd, mem_wr, mem_to_reg};
        want = exp_ctl(s, eq);
        checks++;
        if (int'(upc) != s) begin
            errors++;
            $display("FAIL %s upc got %0d exp %0d", req, upc, s);
        end
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s/R10 ctl in state %0d got %b exp %b", req, s, got, want);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // walk one instruction; alt_op is applied once the path state is reached (R11)
    task automatic run_instr(logic [5:0] op, logic [5:0] alt_op, logic e,
                             int seq_a [5], int n, string req);
        opcode = op;
        eq     = e;
        for (int k = 0; k < n; k++) begin
            if (k == 2) opcode = alt_op;
            check_state(seq_a[k], (k < 2) ? req_of(seq_a[k]) : req);
            step();
        end
        check_state(0, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; opcode = '0; eq = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        check_state(0, "R1");
    endtask

    task automatic t_rtype();
        int s [5] = '{0, 1, 4, 5, 0};
        run_instr(6'b000000, 6'b000000, 1'b0, s, 4, "R4");
    endtask

    task automatic t_ori();
        int s [5] = '{0, 1, 6, 7, 0};
        run_instr(6'b001101, 6'b001101, 1'b1, s, 4, "R5");
    endtask

    task automatic t_load();
        int s [5] = '{0, 1, 8, 9, 10};
        run_instr(6'b100011, 6'b100011, 1'b0, s, 5, "R6");
    endtask

    task automatic t_store();
        int s [5] = '{0, 1, 11, 12, 0};
        run_instr(6'b101011, 6'b101011, 1'b1, s, 4, "R7");
    endtask

    task automatic t_branch(logic e);
        int s [5] = '{0, 1, 3, 0, 0};
        run_instr(6'b000100, 6'b000100, e, s, 3, "R8");
    endtask

    task automatic t_unknown(logic [5:0] op);
        int s [5] = '{0, 1, 0, 0, 0};
        run_instr(op, op, 1'b0, s, 2, "R9");
        checks++;
        if (reg_wr !== 1'b0 || mem_wr !== 1'b0) begin
            errors++;
            $display("FAIL R9 writes got %b%b exp 00", reg_wr, mem_wr);
        end
    endtask

    task automatic t_op_ignored();
        int s [5] = '{0, 1, 8, 9, 10};
        run_instr(6'b100011, 6'b101011, 1'b0, s, 5, "R11");
    endtask

    task automatic t_mid_reset();
        opcode = 6'b100011;
        step(); step(); step();
        check_state(9, "R1");
        rst = 1'b1;
        step();
        rst = 1'b0;
        check_state(0, "R1");
    endtask

    initial begin
        t_reset();
        t_rtype();
        t_ori();
        t_load();
        t_store();
        t_branch(1'b1);
        t_branch(1'b0);
        t_unknown(6'b111111);
        t_unknown(6'b000010);
        t_op_ignored();
        t_mid_reset();
        t_rtype();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired got running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule